// File: doc/BRIEF.md
# Temperature Limit Monitor with Hysteresis

The block watches a single temperature channel. Each time the converter pulses its end-of-conversion strobe, the block adds a signed calibration offset to the raw 8-bit result. The sum saturates at the ends of the signed range. The corrected reading is stored and is then compared against a high limit, a low limit and an over-temperature (THERM) limit. All of these comparisons are signed.

The block keeps a sticky-free status bit. That bit is re-evaluated on every conversion and holds its value between conversions. The block also drives a THERM-mode output. This output engages when the reading rises above the THERM limit. It releases only once the reading has fallen a fixed hysteresis distance below that limit. Each engage event and each release event raises the status bit for that one conversion. The interrupt request follows the status bit unless the channel's mask bit is set.

A flat register port gives access to the offset, the limits and the mask, and shows the measured value and the status. Reads are combinational from the address. Writes take effect at the clock edge.

Top module: `temp_limit_mon`

## Requirements
- R1: After an asynchronous reset, offset, mask, measured value and status read 00h; the high limit reads 7Fh, the low limit 80h and the THERM limit 7Fh; therm_o and irq_o are 0.
- R2: Addresses 0 (offset), 1 (high limit), 2 (low limit), 3 (THERM limit) and 4 (mask) are writable and read back the written byte. The mask keeps only bit 0; its bits 7:1 read 0.
- R3: Address 5 (measured value) and address 6 (status, in bit 0, other bits 0) are read-only: writes to them change nothing.
- R4: On a cycle with eoc_i high, the corrected value (raw_i plus offset, both two's complement) is stored and reads back at address 5 from the next cycle.
- R5: The offset sum saturates to +127 (7Fh) and -128 (80h) instead of wrapping.
- R6: On each strobe the status becomes 1 if the corrected value is signed-greater than the high limit or signed-less than the low limit; a value equal to a limit does not trip it.
- R7: When THERM mode is off and a corrected value is signed-greater than the THERM limit, therm_o goes to 1 and status is 1 for that conversion only.
- R8: While THERM mode is on, it stays on until a corrected value is at or below the THERM limit minus 5 (computed without wrap). That conversion clears therm_o and sets status to 1 for that conversion only.
- R9: irq_o is 1 exactly when status is 1 and mask bit 0 is 0. The mask has no effect on status.
- R10: Without a strobe, the measured value, status and therm_o keep their values whatever raw_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eoc_i | input | 1 | End-of-conversion strobe, one cycle per result |
| raw_i | input | 8 | Raw conversion result, two's complement |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| therm_o | output | 1 | THERM mode active |
| irq_o | output | 1 | Interrupt request |

## Verification
Random raw results run against random offsets, limits and mask settings. This separates a signed comparison from an unsigned one and a saturating sum from a wrapping one, because negative readings and readings near the range ends appear often. Directed ramps step through the values just above the THERM limit, the limit minus 4 and the limit minus 5. These ramps show whether release hysteresis is applied with the correct inclusive bound and whether an event sets the status for one conversion or leaves it stuck. Readings placed exactly on the high and low limits, and idle cycles in which raw_i changes without a strobe, expose off-by-one comparisons and unqualified register updates.

// File: rtl/temp_mon_pkg.sv
package temp_mon_pkg;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADDR_OFFSET = 3'd0;
  localparam logic [AW-1:0] ADDR_HI     = 3'd1;
  localparam logic [AW-1:0] ADDR_LO     = 3'd2;
  localparam logic [AW-1:0] ADDR_THERM  = 3'd3;
  localparam logic [AW-1:0] ADDR_MASK   = 3'd4;
  localparam logic [AW-1:0] ADDR_VALUE  = 3'd5;
  localparam logic [AW-1:0] ADDR_STATUS = 3'd6;
endpackage

// File: rtl/temp_offset_sat.sv
module temp_offset_sat #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] raw_i,
  input  logic [DW-1:0] off_i,
  output logic [DW-1:0] sum_o
);
  localparam logic [DW-1:0] MAX_V = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0] wide;
  logic        ovf;

  always_comb begin
    wide  = {raw_i[DW-1], raw_i} + {off_i[DW-1], off_i};
    ovf   = wide[DW] ^ wide[DW-1];
    sum_o = ovf ? (wide[DW] ? MIN_V : MAX_V) : wide[DW-1:0];
  end

  // R5
  always_comb begin
    sat_pos_chk: assert (!(!raw_i[DW-1] && !off_i[DW-1] && sum_o[DW-1]));
    sat_neg_chk: assert (!(raw_i[DW-1] && off_i[DW-1] && !sum_o[DW-1]));
  end
endmodule

// File: rtl/temp_eval.sv
module temp_eval #(
  parameter int DW   = 8,
  parameter int HYST = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eoc_i,
  input  logic [DW-1:0] corr_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] therm_lim_i,
  output logic [DW-1:0] value_o,
  output logic          status_o,
  output logic          therm_o
);
  localparam logic signed [DW:0] HYST_X = (DW+1)'(HYST);

  logic signed [DW:0] corr_x, lim_x, rel_x;
  logic above_hi, below_lo, over_therm, at_release;
  logic engage, release_ev;
  logic therm_q, status_q;
  logic [DW-1:0] value_q;

  always_comb begin
    corr_x     = {corr_i[DW-1], corr_i};
    lim_x      = {therm_lim_i[DW-1], therm_lim_i};
    rel_x      = lim_x - HYST_X;
    above_hi   = $signed(corr_i) > $signed(hi_i);
    below_lo   = $signed(corr_i) < $signed(lo_i);
    over_therm = $signed(corr_i) > $signed(therm_lim_i);
    at_release = corr_x <= rel_x;
    engage     = !therm_q && over_therm;
    release_ev = therm_q && at_release;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q  <= '0;
      status_q <= 1'b0;
      therm_q  <= 1'b0;
    end else if (eoc_i) begin
      value_q  <= corr_i;
      status_q <= above_hi || below_lo || engage || release_ev;
      therm_q  <= engage || (therm_q && !release_ev);
    end
  end

  assign value_o  = value_q;
  assign status_o = status_q;
  assign therm_o  = therm_q;

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_i |=> $stable(value_q) && $stable(status_q) && $stable(therm_q));
  // R6
  range_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && (above_hi || below_lo) |=> status_q);
  // R7
  engage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && !therm_q && over_therm |=> therm_q && status_q);
  // R8
  therm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && therm_q && !at_release |=> therm_q);
endmodule

// File: rtl/temp_regs.sv
module temp_regs
  import temp_mon_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] value_i,
  input  logic          status_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] offset_o,
  output logic [DW-1:0] hi_o,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] therm_lim_o,
  output logic          mask_o
);
  localparam logic [DW-1:0] MAX_V = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] offset_q, hi_q, lo_q, therm_q;
  logic          mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_q <= '0;
      hi_q     <= MAX_V;
      lo_q     <= MIN_V;
      therm_q  <= MAX_V;
      mask_q   <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_OFFSET: offset_q <= wdata_i;
        ADDR_HI:     hi_q     <= wdata_i;
        ADDR_LO:     lo_q     <= wdata_i;
        ADDR_THERM:  therm_q  <= wdata_i;
        ADDR_MASK:   mask_q   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_OFFSET: rdata_o = offset_q;
      ADDR_HI:     rdata_o = hi_q;
      ADDR_LO:     rdata_o = lo_q;
      ADDR_THERM:  rdata_o = therm_q;
      ADDR_MASK:   rdata_o = {{(DW-1){1'b0}}, mask_q};
      ADDR_VALUE:  rdata_o = value_i;
      ADDR_STATUS: rdata_o = {{(DW-1){1'b0}}, status_i};
      default:     rdata_o = '0;
    endcase
  end

  assign offset_o    = offset_q;
  assign hi_o        = hi_q;
  assign lo_o        = lo_q;
  assign therm_lim_o = therm_q;
  assign mask_o      = mask_q;

  // R2
  offset_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_OFFSET |=> offset_o == $past(wdata_i));
  // R2
  limit_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(hi_q) && $stable(lo_q) && $stable(therm_q) && $stable(mask_q));
endmodule

// File: rtl/temp_limit_mon.sv
module temp_limit_mon
  import temp_mon_pkg::*;
#(
  parameter int DW   = 8,
  parameter int HYST = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eoc_i,
  input  logic [DW-1:0] raw_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          therm_o,
  output logic          irq_o
);
  logic [DW-1:0] offset, hi_lim, lo_lim, therm_lim, corr, value;
  logic          mask, status;

  temp_regs #(.DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .value_i     (value),
    .status_i    (status),
    .rdata_o     (reg_rdata_o),
    .offset_o    (offset),
    .hi_o        (hi_lim),
    .lo_o        (lo_lim),
    .therm_lim_o (therm_lim),
    .mask_o      (mask)
  );

  temp_offset_sat #(.DW(DW)) u_offset (
    .raw_i (raw_i),
    .off_i (offset),
    .sum_o (corr)
  );

  temp_eval #(.DW(DW), .HYST(HYST)) u_eval (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eoc_i       (eoc_i),
    .corr_i      (corr),
    .hi_i        (hi_lim),
    .lo_i        (lo_lim),
    .therm_lim_i (therm_lim),
    .value_o     (value),
    .status_o    (status),
    .therm_o     (therm_o)
  );

  assign irq_o = status && !mask;

  // R9
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mask) && !$stable(irq_o) |-> !$stable(status));
endmodule

// File: tb/temp_limit_mon_tb.sv
module temp_limit_mon_tb;
  logic       clk = 1'b0, rst_n = 1'b0, eoc = 1'b0, we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] raw = 8'd0, wdata = 8'd0;
  logic [7:0] rdata;
  logic       therm, irq;

  int checks = 0, fails = 0;
  int m_off = 0, m_hi = 127, m_lo = -128, m_thr = 127, m_mask = 0;
  int m_val = 0, m_stat = 0, m_therm = 0;

  temp_limit_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .eoc_i(eoc), .raw_i(raw),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .therm_o(therm), .irq_o(irq)
  );

  always #4 clk = ~clk;

  function automatic int sx(logic [7:0] v);
    int r = int'(v);
    if (v[7]) r = r - 256;
    return r;
  endfunction

  function automatic int sat(int a);
    if (a > 127) return 127;
    if (a < -128) return -128;
    return a;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (a)
      3'd0: m_off = sx(d);
      3'd1: m_hi = sx(d);
      3'd2: m_lo = sx(d);
      3'd3: m_thr = sx(d);
      3'd4: m_mask = int'(d[0]);
      default: ;
    endcase
  endtask

  task automatic check_all(string req);
    logic [7:0] d;
    rd(3'd5, d); chk(req, int'(d), m_val);
    rd(3'd6, d); chk(req, int'(d), m_stat);
    chk(req, int'(therm), m_therm);
    chk(req, int'(irq), (m_stat != 0 && m_mask == 0) ? 1 : 0);
  endtask

  task automatic conv(logic [7:0] r, string req);
    int c, ev;
    @(negedge clk);
    eoc = 1'b1; raw = r;
    @(negedge clk);
    eoc = 1'b0;
    c = sat(sx(r) + m_off);
    ev = 0;
    if (m_therm == 0 && c > m_thr) begin m_therm = 1; ev = 1; end
    else if (m_therm == 1 && c <= m_thr - 5) begin m_therm = 0; ev = 1; end
    m_stat = (c > m_hi || c < m_lo || ev != 0) ? 1 : 0;
    m_val = c & 255;
    check_all(req);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    #20 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, d); chk("R1 offset", int'(d), 0);
    rd(3'd1, d); chk("R1 hi", int'(d), 8'h7F);
    rd(3'd2, d); chk("R1 lo", int'(d), 8'h80);
    rd(3'd3, d); chk("R1 therm", int'(d), 8'h7F);
    rd(3'd4, d); chk("R1 mask", int'(d), 0);
    check_all("R1");

    // R2 read/write
    wr(3'd1, 8'h33); rd(3'd1, d); chk("R2 hi", int'(d), 8'h33);
    wr(3'd2, 8'hC4); rd(3'd2, d); chk("R2 lo", int'(d), 8'hC4);
    wr(3'd3, 8'h5A); rd(3'd3, d); chk("R2 therm", int'(d), 8'h5A);
    wr(3'd0, 8'hFD); rd(3'd0, d); chk("R2 offset", int'(d), 8'hFD);
    wr(3'd4, 8'hFE); rd(3'd4, d); chk("R2 mask", int'(d), 0);
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R2 mask", int'(d), 1);
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h7F); wr(3'd2, 8'h80); wr(3'd3, 8'h7F);

    // R4 offset -3 applied
    conv(8'd50, "R4");
    chk("R4 value", m_val, 47);
    // R3 read-only
    wr(3'd5, 8'h55); wr(3'd6, 8'h55);
    check_all("R3");

    // R5 saturation
    wr(3'd0, 8'h7F); conv(8'h7F, "R5"); chk("R5 max", m_val, 8'h7F);
    wr(3'd0, 8'h80); conv(8'h80, "R5"); chk("R5 min", m_val, 8'h80);
    wr(3'd0, 8'h00);

    // R6 limits, equality does not trip
    wr(3'd1, 8'd40); wr(3'd2, 8'hF6);
    conv(8'd40, "R6"); chk("R6 eq hi", m_stat, 0);
    conv(8'd41, "R6"); chk("R6 above", m_stat, 1);
    conv(8'hF6, "R6"); chk("R6 eq lo", m_stat, 0);
    conv(8'hF5, "R6"); chk("R6 below", m_stat, 1);

    // R7 / R8 THERM hysteresis
    wr(3'd1, 8'h7F); wr(3'd2, 8'h80); wr(3'd3, 8'd60);
    conv(8'd60, "R7");
    conv(8'd61, "R7"); chk("R7 engage", m_therm, 1);
    conv(8'd61, "R7");
    conv(8'd56, "R8");
    conv(8'd55, "R8"); chk("R8 release", m_therm, 0);
    conv(8'd55, "R8");

    // R9 mask
    wr(3'd1, 8'd10);
    conv(8'd20, "R9");
    wr(3'd4, 8'h01); check_all("R9 masked");
    wr(3'd4, 8'h00); check_all("R9 unmasked");

    // R10 idle hold
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      raw = 8'($urandom);
    end
    @(negedge clk);
    check_all("R10");

    // random mix
    for (int i = 0; i < 500; i++) begin
      int sel = int'($urandom % 16);
      if (sel < 2) wr(3'($urandom % 4), 8'($urandom));
      else if (sel == 2) wr(3'd4, 8'($urandom));
      else if (sel == 3) begin
        @(negedge clk); raw = 8'($urandom);
        @(negedge clk); check_all("R10");
      end else conv(8'($urandom), "R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule